// File: doc/BRIEF.md
# Barrel-Threaded Instruction Sequencer

This block is the front end of a free-running barrel processor. It keeps one program counter for each of a fixed number of hardware threads (ten by default) and serves the threads in a strict round-robin order, one thread per clock. In each cycle it presents the current thread's counter to a separate, asynchronously read instruction ROM. It splits the returned word into an operation code, two read addresses and a write address. It registers these fields together with the thread number and raises a single valid strobe. In the same cycle it advances that thread's counter.

There is no stall, halt or hazard logic. Each thread receives exactly one issue slot in every rotation of NUM_THREADS cycles. A fetch always has a fixed latency of one register stage, and the datapath downstream can count on that. The thread number that goes out with each instruction lets shared code pick its own program path. Instruction memory is private to this block, so a fetch never waits behind a data access.

Top module: `barrel_issue_seq`

## Requirements
- R1: From the first rising clock edge after reset is released, `iss_valid` is 1 on every cycle, so one instruction is issued per clock.
- R2: The issued thread numbers follow the cycle 1, 2, …, NUM_THREADS, 1, 2, … with no skip and no repeat.
- R3: `iss_tid` is the thread number in the range 1 to NUM_THREADS, not a zero-based index.
- R4: The ROM word is split with the opcode in its top OP_W bits, the first read address in the next ADDR_W bits, the second read address in the next ADDR_W bits, and the write address in the low ADDR_W bits.
- R5: An opcode of 0 is a no-operation. This includes an all-zero or empty word. For a no-operation, both read addresses and the write address are issued as 0, whatever the word holds.
- R6: While `rst_n` is low, `iss_valid`, `iss_op` and `iss_tid` are 0. After release, thread k starts at PC (k-1)*START_STRIDE and the first issue belongs to thread 1.
- R7: A thread's PC is the ROM address fetched in its slot. It increases by exactly one after that slot and does not change in any other thread's slot.
- R8: A PC increments modulo 2^PC_W, so the step after the all-ones address is address 0.
- R9: The fields and thread number seen at the outputs are the registered decode of the word at `rom_addr` on the preceding clock edge, which is a fixed one-cycle fetch latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | PC_W | Fetch address: the PC of the thread in the current slot |
| rom_word | input | OP_W+3*ADDR_W | Instruction word returned combinationally by the ROM |
| iss_valid | output | 1 | The issue fields below are valid |
| iss_op | output | OP_W | Issued operation code |
| iss_rd_a | output | ADDR_W | Issued first read address |
| iss_rd_b | output | ADDR_W | Issued second read address |
| iss_wr | output | ADDR_W | Issued write address |
| iss_tid | output | $clog2(NUM_THREADS+1) | Issued thread number, 1 to NUM_THREADS |

## Verification
The rotation wrap from the last thread back to thread 1 can fall in the same cycle as that thread's PC rolling over from the all-ones address to 0. The bench provokes this by giving the last thread a start address of 225 with 8-bit PCs. After 31 of its slots, the bench checks that the issue after thread 10's fetch at 255 carries tid 1, and that thread 10's following fetch is at address 0. A second coincidence is a no-operation word whose address fields are nonzero, issued in the same cycle as a normal PC step. The bench checks that the addresses are cleared and that the counter still advances.

// File: rtl/bis_pkg.sv
package bis_pkg;

   typedef enum logic {
      WRAP_NATURAL,
      WRAP_COMPARE
   } wrap_kind_e;

   function automatic wrap_kind_e pick_wrap(input int unsigned count);
      if ((count & (count - 1)) == 0) return WRAP_NATURAL;
      return WRAP_COMPARE;
   endfunction

endpackage

// File: rtl/bis_slot_ring.sv
module bis_slot_ring #(
   parameter int unsigned NUM_THREADS = 10,
   parameter int unsigned SLOT_W      = $clog2(NUM_THREADS)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [SLOT_W-1:0] slot
);
   import bis_pkg::*;

   localparam wrap_kind_e WRAP = pick_wrap(NUM_THREADS);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_THREADS - 1);

   logic [SLOT_W-1:0] slot_nxt;

   generate
      if (WRAP == WRAP_NATURAL) begin : g_natural
         always_comb slot_nxt = slot + SLOT_W'(1);
      end else begin : g_compare
         always_comb slot_nxt = (slot == LAST) ? '0 : slot + SLOT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= '0;
      else        slot <= slot_nxt;
   end
endmodule

// File: rtl/bis_pc_bank.sv
module bis_pc_bank #(
   parameter int unsigned NUM_THREADS  = 10,
   parameter int unsigned PC_W         = 8,
   parameter int unsigned START_STRIDE = 25,
   parameter int unsigned SLOT_W       = $clog2(NUM_THREADS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] slot,
   output logic [PC_W-1:0]   fetch_pc
);
   logic [PC_W-1:0] pc_q [NUM_THREADS];

   generate
      for (genvar k = 0; k < NUM_THREADS; k++) begin : g_thread
         localparam logic [PC_W-1:0] START = PC_W'(k * START_STRIDE);
         logic own_slot;
         assign own_slot = (slot == SLOT_W'(k));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pc_q[k] <= START;
            else if (own_slot) pc_q[k] <= pc_q[k] + PC_W'(1);
         end
      end
   endgenerate

   always_comb begin
      fetch_pc = '0;
      for (int k = 0; k < NUM_THREADS; k++)
         if (slot == SLOT_W'(k)) fetch_pc = pc_q[k];
   end
endmodule

// File: rtl/bis_word_decode.sv
module bis_word_decode #(
   parameter int unsigned OP_W   = 6,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WORD_W = OP_W + 3 * ADDR_W
) (
   input  logic [WORD_W-1:0] word,
   output logic [OP_W-1:0]   op,
   output logic [ADDR_W-1:0] rd_a,
   output logic [ADDR_W-1:0] rd_b,
   output logic [ADDR_W-1:0] wr
);
   logic is_nop;

   always_comb begin
      op     = word[WORD_W-1 -: OP_W];
      is_nop = (op == '0);
      rd_a   = is_nop ? '0 : word[3*ADDR_W-1 -: ADDR_W];
      rd_b   = is_nop ? '0 : word[2*ADDR_W-1 -: ADDR_W];
      wr     = is_nop ? '0 : word[ADDR_W-1:0];
   end
endmodule

// File: rtl/barrel_issue_seq.sv
module barrel_issue_seq #(
   parameter int unsigned NUM_THREADS  = 10,
   parameter int unsigned PC_W         = 8,
   parameter int unsigned OP_W         = 6,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned START_STRIDE = 25,
   parameter int unsigned WORD_W       = OP_W + 3 * ADDR_W,
   parameter int unsigned TID_W        = $clog2(NUM_THREADS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PC_W-1:0]   rom_addr,
   input  logic [WORD_W-1:0] rom_word,
   output logic              iss_valid,
   output logic [OP_W-1:0]   iss_op,
   output logic [ADDR_W-1:0] iss_rd_a,
   output logic [ADDR_W-1:0] iss_rd_b,
   output logic [ADDR_W-1:0] iss_wr,
   output logic [TID_W-1:0]  iss_tid
);
   localparam int unsigned SLOT_W = $clog2(NUM_THREADS);

   generate
      if (NUM_THREADS < 2) begin : g_chk_threads
         $error("barrel_issue_seq: NUM_THREADS must be at least 2");
      end
      if ((NUM_THREADS - 1) * START_STRIDE >= (1 << PC_W)) begin : g_chk_stride
         $error("barrel_issue_seq: start addresses exceed PC range");
      end
      if (WORD_W != OP_W + 3 * ADDR_W) begin : g_chk_word
         $error("barrel_issue_seq: WORD_W must equal OP_W + 3*ADDR_W");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic [OP_W-1:0]   dec_op;
   logic [ADDR_W-1:0] dec_rd_a, dec_rd_b, dec_wr;

   bis_slot_ring #(
      .NUM_THREADS(NUM_THREADS),
      .SLOT_W     (SLOT_W)
   ) u_ring (
      .clk  (clk),
      .rst_n(rst_n),
      .slot (slot)
   );

   bis_pc_bank #(
      .NUM_THREADS (NUM_THREADS),
      .PC_W        (PC_W),
      .START_STRIDE(START_STRIDE),
      .SLOT_W      (SLOT_W)
   ) u_pcs (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot    (slot),
      .fetch_pc(rom_addr)
   );

   bis_word_decode #(
      .OP_W  (OP_W),
      .ADDR_W(ADDR_W),
      .WORD_W(WORD_W)
   ) u_dec (
      .word(rom_word),
      .op  (dec_op),
      .rd_a(dec_rd_a),
      .rd_b(dec_rd_b),
      .wr  (dec_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iss_valid <= 1'b0;
         iss_op    <= '0;
         iss_rd_a  <= '0;
         iss_rd_b  <= '0;
         iss_wr    <= '0;
         iss_tid   <= '0;
      end else begin
         iss_valid <= 1'b1;
         iss_op    <= dec_op;
         iss_rd_a  <= dec_rd_a;
         iss_rd_b  <= dec_rd_b;
         iss_wr    <= dec_wr;
         iss_tid   <= TID_W'(slot) + TID_W'(1);
      end
   end
endmodule

// File: rtl/barrel_issue_seq_chk.sv
module barrel_issue_seq_chk #(
   parameter int unsigned NUM_THREADS = 10,
   parameter int unsigned OP_W        = 6,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned TID_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iss_valid,
   input logic [OP_W-1:0]   iss_op,
   input logic [ADDR_W-1:0] iss_rd_a,
   input logic [ADDR_W-1:0] iss_rd_b,
   input logic [ADDR_W-1:0] iss_wr,
   input logic [TID_W-1:0]  iss_tid
);
   localparam logic [TID_W-1:0] TOP_TID = TID_W'(NUM_THREADS);

   // R1: once issuing, the strobe never drops while out of reset
   a_r1_issue_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> iss_valid);

   // R2: consecutive issues come from consecutive threads
   a_r2_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && $past(iss_valid)) |->
         (iss_tid == (($past(iss_tid) == TOP_TID) ? TID_W'(1) : $past(iss_tid) + TID_W'(1))));

   // R3: tag is one-based and bounded
   a_r3_tid_range: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (iss_tid >= TID_W'(1) && iss_tid <= TOP_TID));

   // R5: a no-operation carries no addresses
   a_r5_nop_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_op == '0) |-> (iss_rd_a == '0 && iss_rd_b == '0 && iss_wr == '0));

   // R6: first issue after reset belongs to thread 1
   a_r6_first_thread: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iss_valid) |-> (iss_tid == TID_W'(1)));
endmodule

bind barrel_issue_seq barrel_issue_seq_chk #(
   .NUM_THREADS(NUM_THREADS),
   .OP_W       (OP_W),
   .ADDR_W     (ADDR_W),
   .TID_W      (TID_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iss_valid(iss_valid),
   .iss_op   (iss_op),
   .iss_rd_a (iss_rd_a),
   .iss_rd_b (iss_rd_b),
   .iss_wr   (iss_wr),
   .iss_tid  (iss_tid)
);

// File: tb/test_barrel_issue_seq.sv
module test_barrel_issue_seq;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 10;
   localparam int STR = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rom_addr;
   logic [29:0] rom_word;
   logic        iss_valid;
   logic [5:0]  iss_op;
   logic [7:0]  iss_rd_a, iss_rd_b, iss_wr;
   logic [3:0]  iss_tid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // ROM contents: opcode zero on multiples of 7, otherwise a nonzero code
   function automatic logic [29:0] rom_fn(input logic [7:0] a);
      logic [5:0] op;
      op = ((a % 7) == 0) ? 6'd0 : 6'(a % 63) + 6'd1;
      return {op, a ^ 8'h5A, a + 8'd17, ~a};
   endfunction

   assign rom_word = rom_fn(rom_addr);

   barrel_issue_seq i_barrel_issue_seq (
      .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_word(rom_word),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_rd_a(iss_rd_a),
      .iss_rd_b(iss_rd_b), .iss_wr(iss_wr), .iss_tid(iss_tid)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare the issued fields with the word at address pc for thread tid
   task automatic check_issue(input string req, input logic [7:0] pc, input logic [3:0] tid);
      logic [29:0] w;
      logic [31:0] exp_fields, act_fields;
      w = rom_fn(pc);
      exp_fields = (w[29:24] == 6'd0) ? 32'd0 : {8'(w[29:24]), w[23:0]};
      act_fields = {2'b00, iss_op, iss_rd_a, iss_rd_b, iss_wr};
      check(iss_valid === 1'b1, {req, " R1 valid"}, 32'(iss_valid), 32'd1);
      check(iss_tid === tid, {req, " R2/R3 tid"}, 32'(iss_tid), 32'(tid));
      check(act_fields === exp_fields, {req, " R4 fields"}, act_fields, exp_fields);
   endtask

   // first twelve issues: {tid, pc}
   localparam logic [11:0] VEC [12] = '{
      {4'd1, 8'd0},   {4'd2, 8'd25},  {4'd3, 8'd50},  {4'd4, 8'd75},
      {4'd5, 8'd100}, {4'd6, 8'd125}, {4'd7, 8'd150}, {4'd8, 8'd175},
      {4'd9, 8'd200}, {4'd10, 8'd225}, {4'd1, 8'd1},  {4'd2, 8'd26}
   };

   initial begin
      logic [7:0] mpc [N];
      int s;
      int wraps_seen;
      wraps_seen = 0;

      // R6: reset state
      repeat (3) @(negedge clk);
      check(iss_valid === 1'b0, "R6 valid in reset", 32'(iss_valid), 32'd0);
      check(iss_tid === 4'd0 && iss_op === 6'd0, "R6 tid/op in reset", {iss_tid, iss_op}, 32'd0);
      check(rom_addr === 8'd0, "R6 first fetch address", 32'(rom_addr), 32'd0);
      rst_n = 1'b1;

      // table walk: R2 rotation, R4 decode, R6 start addresses
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         check_issue($sformatf("R6 vec%0d", i), VEC[i][7:0], VEC[i][11:8]);
      end

      // free-running model
      for (int k = 0; k < N; k++) mpc[k] = 8'(k * STR + ((k < 2) ? 2 : 1));
      s = 2;
      check(rom_addr === mpc[s], "R9 fetch address before edge", 32'(rom_addr), 32'(mpc[s]));
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         check_issue("R7 model", mpc[s], 4'(s + 1));
         if (rom_fn(mpc[s]) >> 24 == 0)
            check(iss_rd_a === 8'd0 && iss_wr === 8'd0 && iss_rd_b === 8'd0,
                  "R5 nop addresses", {iss_rd_a, iss_rd_b, iss_wr}, 32'd0);
         mpc[s] = mpc[s] + 8'd1;
         if (s == N - 1 && mpc[s] == 8'd0) wraps_seen++;
         s = (s == N - 1) ? 0 : s + 1;
         check(rom_addr === mpc[s], "R9/R7 next fetch address", 32'(rom_addr), 32'(mpc[s]));
         if (s == N - 1 && mpc[s] == 8'd0)
            check(rom_addr === 8'd0, "R8 PC wrap to zero", 32'(rom_addr), 32'd0);
      end
      check(wraps_seen == 1, "R8 wrap reached", 32'(wraps_seen), 32'd1);

      // reset again mid-run
      rst_n = 1'b0;
      #1;
      check(iss_valid === 1'b0, "R6 async reset clears valid", 32'(iss_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_issue("R6 restart thread 1", 8'd0, 4'd1);
      @(negedge clk);
      check_issue("R6 restart thread 2", 8'd25, 4'd2);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule